// File: doc/BRIEF.md
# Reset-Safe Instruction Fetch Stage

This block is the fetch front end of a small 32-bit RISC pipeline. It holds the program counter and drives it to the instruction cache as the fetch address. It loads the instruction register from the cache's code word, and it steers the program counter when the instruction register holds a PC-relative jump or a register jump. The cache, full decode and the later pipeline stages lie outside the block.

After a reset the cache keeps showing whatever word it held before the reset, until its first code refill completes. That word is not valid. The cache also does not raise its stall input until one cycle after reset. To deal with both, the block keeps a sticky valid-code flag. Reset clears the flag and a completed refill sets it. While the flag is low, every unstalled cycle loads an all-zero word (a no-operation) into the instruction register, and the program counter stays on its address, so that address is fetched again. The jump that sits at the reset vector is therefore captured only once the word is real. The program counter then moves past it normally, and the jump resolves to the same target after every reset.

Top module: `fetch_front`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the next state is `fetch_addr_o` = `RESET_VEC`, `instr_o` = 0 and `code_valid_o` = 0.
- R2: `code_valid_o` rises on the edge after one where `refill_done_i` is high. It then stays high, whatever the stall and refill inputs do, until the next reset.
- R3: On an edge where `code_valid_o` is low and `cache_stall_i` is low, `instr_o` becomes 32'h0 whatever `code_word_i` carries, and `fetch_addr_o` keeps its value.
- R4: On an edge where `cache_stall_i` is high, both `fetch_addr_o` and `instr_o` keep their values.
- R5: An advancing edge is one where `code_valid_o` is high and `cache_stall_i` is low. On an advancing edge, `instr_o` takes `code_word_i`. If the old `instr_o` is not a jump, `fetch_addr_o` steps by 4.
- R6: A relative jump has bits [31:26] = 6'b000100 and a signed word offset in bits [15:0]. On the next advancing edge with it in `instr_o`, `fetch_addr_o` becomes the current `fetch_addr_o` (the address after the jump) plus the sign-extended offset shifted left by 2.
- R7: A register jump has bits [31:26] = 6'b000000 and bits [5:0] = 6'b001000. On the next advancing edge with it in `instr_o`, `fetch_addr_o` becomes `reg_target_i` with bits [1:0] cleared.
- R8: When the word at `RESET_VEC` is a relative jump, the fetch address after that jump resolves is `RESET_VEC` + 4 + 4*offset. This holds after every one of several back-to-back resets, whatever stale word the cache shows before its refill.
- R9: The all-zero word is not decoded as a jump. With it in `instr_o`, an advancing edge steps `fetch_addr_o` by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_stall_i | input | 1 | Cache busy; fetch state holds |
| refill_done_i | input | 1 | A code refill completed this cycle |
| code_word_i | input | 32 | Word the cache presents for `fetch_addr_o` |
| reg_target_i | input | ADDR_W | Register value used by a register jump |
| fetch_addr_o | output | ADDR_W | Program counter, used as the fetch address |
| instr_o | output | 32 | Instruction register |
| code_valid_o | output | 1 | Sticky flag: cache code is trustworthy |

## Verification
A valid-code flag that is stuck or set too early lets a stale word into `instr_o` on the edge right after reset. If that stale word is a jump, `fetch_addr_o` goes wrong one edge later. A program counter that advances while the flag is low shows up as a reset-vector jump target 4 bytes too low or too high, at the first advancing edge after the jump. A wrong jump decode makes `fetch_addr_o` depart from the expected next address on the edge that consumes the jump, so every fault is visible at the ports within two cycles of its cause.

// File: rtl/fetch_front_pkg.sv
package fetch_front_pkg;
   localparam int INSN_W = 32;
   localparam int OFF_W  = 16;
   localparam int OPC_LO = 26;
   localparam logic [5:0] OPC_RELJ  = 6'b000100;
   localparam logic [5:0] OPC_SPEC  = 6'b000000;
   localparam logic [5:0] FN_REGJ   = 6'b001000;

   typedef enum logic [1:0] {
      REDIR_SEQ = 2'd0,
      REDIR_REL = 2'd1,
      REDIR_REG = 2'd2
   } redir_e;
endpackage

// File: rtl/fetch_valid_flag.sv
module fetch_valid_flag (
   input  logic clk,
   input  logic rst,
   input  logic refill_done_i,
   output logic valid_o
);
   always_ff @(posedge clk) begin
      if (rst)                valid_o <= 1'b0;
      else if (refill_done_i) valid_o <= 1'b1;
   end

   a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> valid_o);
   a_r2_set_after_refill: assert property (@(posedge clk) disable iff (rst)
      refill_done_i |=> valid_o);
endmodule

// File: rtl/fetch_ir_reg.sv
module fetch_ir_reg
   import fetch_front_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              stall_i,
   input  logic              valid_i,
   input  logic [INSN_W-1:0] word_i,
   output logic [INSN_W-1:0] ir_o
);
   // masking with a registered flag: one AND level on the cache-to-IR path
   logic [INSN_W-1:0] masked_word;
   assign masked_word = word_i & {INSN_W{valid_i}};

   always_ff @(posedge clk) begin
      if (rst)          ir_o <= '0;
      else if (!stall_i) ir_o <= masked_word;
   end

   a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
      (!valid_i && !stall_i) |=> (ir_o == '0));
   a_r4_ir_hold: assert property (@(posedge clk) disable iff (rst)
      stall_i |=> $stable(ir_o));
endmodule

// File: rtl/fetch_jump_decode.sv
module fetch_jump_decode
   import fetch_front_pkg::*;
#(
   parameter bit REGJ_EN = 1'b1
) (
   input  logic [INSN_W-1:0] ir_i,
   output redir_e            kind_o,
   output logic [OFF_W-1:0]  off_o
);
   logic [5:0] opc;
   logic       rel_hit;
   logic       reg_hit;
   logic       unused_fields;

   assign opc           = ir_i[INSN_W-1:OPC_LO];
   assign off_o         = ir_i[OFF_W-1:0];
   assign rel_hit       = (opc == OPC_RELJ);
   assign unused_fields = ^ir_i[OPC_LO-1:OFF_W];

   generate
      if (REGJ_EN) begin : g_regj
         assign reg_hit = (opc == OPC_SPEC) && (ir_i[5:0] == FN_REGJ);
      end else begin : g_no_regj
         assign reg_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (rel_hit)      kind_o = REDIR_REL;
      else if (reg_hit) kind_o = REDIR_REG;
      else              kind_o = REDIR_SEQ;
   end

   // R9: the all-zero no-op must never be seen as a jump
   always_comb begin
      if (ir_i == '0) a_r9_zero_is_seq: assert (kind_o == REDIR_SEQ);
   end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
   import fetch_front_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance_i,
   input  redir_e            kind_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [ADDR_W-1:0] reg_target_i,
   output logic [ADDR_W-1:0] pc_o
);
   localparam int EXT_W = ADDR_W - OFF_W - 2;

   logic [ADDR_W-1:0] off_bytes;
   logic [ADDR_W-1:0] pc_next;
   logic              unused_low;

   assign off_bytes  = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
   assign unused_low = ^reg_target_i[1:0];

   always_comb begin
      unique case (kind_i)
         REDIR_REL: pc_next = pc_o + off_bytes;
         REDIR_REG: pc_next = {reg_target_i[ADDR_W-1:2], 2'b00};
         default:   pc_next = pc_o + ADDR_W'(4);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)            pc_o <= RESET_VEC;
      else if (advance_i) pc_o <= pc_next;
   end

   a_r4_pc_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !advance_i |=> $stable(pc_o));
   a_r5_seq_step: assert property (@(posedge clk) disable iff (rst)
      (advance_i && kind_i == REDIR_SEQ) |=> (pc_o == $past(pc_o) + ADDR_W'(4)));
   a_r7_word_aligned: assert property (@(posedge clk) disable iff (rst)
      (advance_i && kind_i == REDIR_REG) |=> (pc_o[1:0] == 2'b00));
endmodule

// File: rtl/fetch_front.sv
module fetch_front
   import fetch_front_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0000_0100),
   parameter bit                REGJ_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cache_stall_i,
   input  logic              refill_done_i,
   input  logic [31:0]       code_word_i,
   input  logic [ADDR_W-1:0] reg_target_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic [31:0]       instr_o,
   output logic              code_valid_o
);
   generate
      if (ADDR_W < OFF_W + 2 || ADDR_W > 64) begin : g_bad_width
         $error("fetch_front: ADDR_W out of range");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("fetch_front: RESET_VEC must be word aligned");
      end
   endgenerate

   logic   advance;
   redir_e kind;
   logic [OFF_W-1:0] off;

   assign advance = code_valid_o && !cache_stall_i;

   fetch_valid_flag u_valid (
      .clk           (clk),
      .rst           (rst),
      .refill_done_i (refill_done_i),
      .valid_o       (code_valid_o)
   );

   fetch_ir_reg u_ir (
      .clk     (clk),
      .rst     (rst),
      .stall_i (cache_stall_i),
      .valid_i (code_valid_o),
      .word_i  (code_word_i),
      .ir_o    (instr_o)
   );

   fetch_jump_decode #(.REGJ_EN(REGJ_EN)) u_dec (
      .ir_i   (instr_o),
      .kind_o (kind),
      .off_o  (off)
   );

   fetch_pc_unit #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
      .clk          (clk),
      .rst          (rst),
      .advance_i    (advance),
      .kind_i       (kind),
      .off_i        (off),
      .reg_target_i (reg_target_i),
      .pc_o         (fetch_addr_o)
   );

   a_r3_pc_frozen_until_valid: assert property (@(posedge clk) disable iff (rst)
      !code_valid_o |=> (fetch_addr_o == $past(fetch_addr_o)));
endmodule

// File: tb/fetch_front_bench.sv
module fetch_front_bench;
   localparam int          CLK_PERIOD = 10;
   localparam int          AW = 32;
   localparam logic [31:0] RV = 32'h0000_0100;
   localparam logic [31:0] STALE_WORD = 32'h1000_FFF0; // a relative jump

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic stall = 1'b0;
   logic rdone = 1'b0;
   logic stale = 1'b1;
   logic [31:0] rtgt = '0;
   logic [31:0] code_word;
   logic [31:0] fetch_addr;
   logic [31:0] instr;
   logic        cvalid;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] e_pc = RV;
   logic [31:0] e_ir = '0;
   logic        e_ok = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mem(input logic [31:0] a);
      logic [31:0] x;
      if (a == RV) return {6'b000100, 10'h0, 16'd8};
      x = a * 32'h9E37_79B1;
      case (x[31:29])
         3'd0:    return {6'b000100, 10'h0, {8{x[7]}}, x[7:0]};
         3'd1:    return 32'h0000_0008;
         default: return {6'b001001, x[25:0]};
      endcase
   endfunction

   function automatic bit is_rel(input logic [31:0] w);
      return w[31:26] == 6'b000100;
   endfunction
   function automatic bit is_jr(input logic [31:0] w);
      return w[31:26] == 6'b000000 && w[5:0] == 6'b001000;
   endfunction

   assign code_word = stale ? STALE_WORD : mem(fetch_addr);

   fetch_front #(.ADDR_W(AW), .RESET_VEC(RV)) u_fetch_front (
      .clk (clk), .rst (rst), .cache_stall_i (stall), .refill_done_i (rdone),
      .code_word_i (code_word), .reg_target_i (rtgt),
      .fetch_addr_o (fetch_addr), .instr_o (instr), .code_valid_o (cvalid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge: drive inputs, predict, clock, compare
   task automatic step(input bit r, input bit s, input bit d, input bit stl, input logic [31:0] tg);
      string tag;
      logic [31:0] w;
      rst = r; stall = s; rdone = d; stale = stl; rtgt = tg;
      w = stl ? STALE_WORD : mem(e_pc);
      if (r) begin
         tag = "R1"; e_pc = RV; e_ir = '0; e_ok = 1'b0;
      end else begin
         if (s)          tag = "R4";
         else if (!e_ok) tag = "R3";
         else if (is_rel(e_ir)) tag = "R6";
         else if (is_jr(e_ir))  tag = "R7";
         else if (e_ir == '0)   tag = "R9";
         else tag = "R5";
         if (!s && !e_ok) e_ir = '0;
         else if (!s) begin
            if (is_rel(e_ir))     e_pc = e_pc + {{14{e_ir[15]}}, e_ir[15:0], 2'b00};
            else if (is_jr(e_ir)) e_pc = {tg[31:2], 2'b00};
            else                  e_pc = e_pc + 32'd4;
            e_ir = w;
         end
         e_ok = e_ok | d;
      end
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk({tag, " pc"}, fetch_addr, e_pc);
      chk({tag, " ir"}, instr, e_ir);
      chk((r ? "R1 valid" : "R2 valid"), {31'h0, cvalid}, {31'h0, e_ok});
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      step(1, 0, 0, 1, 0);
      // R8: repeated resets, stale jump shown before refill each time
      for (int k = 0; k < 5; k++) begin
         step(1, 0, 0, 1, 0);
         step(0, 0, 0, 1, 0);            // R3 zero fill, pc held
         for (int j = 0; j < k + 1; j++) step(0, 1, 0, 1, 0);
         step(0, 0, 1, 0, 0);            // refill done, still not valid
         step(0, 0, 0, 0, 0);            // captures jump at RV, pc -> RV+4
         step(0, 0, 0, 0, 0);            // jump resolves
         chk("R8 target", fetch_addr, RV + 32'd4 + 32'd32);
      end
      // R2: valid stays up through stalls and refill pulses
      step(0, 1, 1, 0, 0);
      step(0, 1, 0, 0, 0);
      chk("R2 sticky", {31'h0, cvalid}, 32'h1);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         bit r, s, d;
         r = ($urandom % 64) == 0;
         s = ($urandom % 4) == 0;
         d = ($urandom % 8) == 0;
         step(r, s, d, !e_ok && !r, $urandom);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule